// File: doc/BRIEF.md
# Warp instruction issue dispatcher

This block is the issue stage owned by one warp scheduler. In each cycle it looks at the head of the selected warp's instruction buffer, up to `MAX_ISSUE` entries deep. It decides which compute pipe each instruction goes to: single-precision float, integer, double-precision, special-function or tensor. The decision depends on the opcode class, on which optional pipe types are fitted, on whether each pipe has an issue slot free, and on the pipe used by the instruction issued just before it in the same cycle.

Issue is strictly in order. The first instruction that cannot be routed ends the cycle, and nothing behind it is sent. Two mode straps shape the behaviour. With different-unit dual issue enabled, back-to-back issues within a cycle may not target the same pipe type, and a tensor op may not follow a single-precision op. With per-scheduler slots enabled, a pipe counts as free only when the slot at this scheduler's index is free. Otherwise every free slot of the pipe is shared capacity, and each issue in the cycle consumes one of them.

The per-slot routing decisions are registered. One cycle after the inputs are presented, the block shows a one-hot strobe per issued slot naming the pipe, together with the number of instructions issued.

Top module: `warp_issue_dispatch`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released with no stimulus, `o_strobe` and `o_count` are all zero.
- R2: Nothing issues while `warp_wait` is high. Slot k is considered only when `ibuf_vld[k]` is set and every earlier slot issued in the same cycle, so the first slot that is empty or cannot be routed stops the cycle. Results appear one clock after the inputs.
- R3: An op of class INT (1) or ALU_SFU (4) goes to the integer pipe when `int_units_en` is set, the integer pipe has capacity, and different-unit mode does not forbid integer after integer.
- R4: When the integer route is not taken, an op of class SP (0), INT (1) or ALU_SFU (4) goes to the single-precision pipe if that pipe has capacity, either `int_units_en` is clear or the class is SP, and different-unit mode does not forbid SP after SP.
- R5: With `dp_units_en` set, a DP op (class 2) goes only to the double-precision pipe, when it has capacity and is not blocked by different-unit mode.
- R6: The special-function pipe takes a DP op when `dp_units_en` is clear, an SFU op (class 3), or an ALU_SFU op that neither the integer nor the single-precision route accepted. It needs capacity and must not follow an SFU issue in different-unit mode.
- R7: A tensor op (class 5) goes to the tensor pipe when it has capacity. In different-unit mode it is refused directly after a single-precision issue, and it may follow another tensor issue.
- R8: With `diff_unit_en` set, two consecutive issued slots never use the same SP, INT, DP or SFU pipe. With the strap clear, repeats are allowed.
- R9: With `sub_core_en` set, a pipe's capacity is the single bit of its free vector indexed by `sched_id`. With it clear, capacity is the number of set bits. Each issue in a cycle consumes one unit of that pipe's capacity.
- R10: A MEM op (class 6) or the reserved class 7 never produces a strobe, and it stops the cycle.
- R11: Slot k's strobe is `o_strobe[5k+4:5k]` with bit 0 SP, 1 INT, 2 DP, 3 SFU, 4 tensor. Each slot field is one-hot or zero, issued slots are contiguous from slot 0, and `o_count` equals the number of strobe bits set, at most `MAX_ISSUE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| diff_unit_en | input | 1 | Forbid same pipe type in consecutive issues of one cycle |
| sub_core_en | input | 1 | Per-scheduler slot ownership |
| int_units_en | input | 1 | Integer pipe is fitted |
| dp_units_en | input | 1 | Double-precision pipe is fitted |
| sched_id | input | SID_W | Index of this scheduler's slot |
| warp_wait | input | 1 | Selected warp is stalled |
| ibuf_vld | input | MAX_ISSUE | Buffer entry k present |
| ibuf_cls | input | 3*MAX_ISSUE | Opcode class of entry k at bits [3k+2:3k] |
| sp_free | input | NUM_SCHED | Single-precision issue slots free |
| int_free | input | NUM_SCHED | Integer issue slots free |
| dp_free | input | NUM_SCHED | Double-precision issue slots free |
| sfu_free | input | NUM_SCHED | Special-function issue slots free |
| tc_free | input | NUM_SCHED | Tensor issue slots free |
| o_strobe | output | 5*MAX_ISSUE | Registered per-slot one-hot pipe strobes |
| o_count | output | CNT_W | Registered number of instructions issued |

## Verification
The routing choice and the capacity accounting can both decide the same slot in the same cycle. In that case, whether the second instruction is refused because of the previous pipe type or because the first issue used up the only free slot of the pipe has to be told apart. The bench provokes this with the same opcode pair under one and two free slots, in shared and per-scheduler mode, and with and without different-unit mode. Each case is judged against the exact strobe pattern and count that the requirements predict. Tensor-after-tensor and SFU-after-tensor pairs separate the special tensor blocking rule from the general same-type rule.

// File: rtl/wid_pkg.sv
package wid_pkg;

  localparam int NPIPE = 5;

  typedef enum logic [2:0] {
    OC_SP     = 3'd0,
    OC_INT    = 3'd1,
    OC_DP     = 3'd2,
    OC_SFU    = 3'd3,
    OC_ALUSFU = 3'd4,
    OC_TC     = 3'd5,
    OC_MEM    = 3'd6,
    OC_RSV    = 3'd7
  } opclass_e;

  typedef enum logic [2:0] {
    PP_SP   = 3'd0,
    PP_INT  = 3'd1,
    PP_DP   = 3'd2,
    PP_SFU  = 3'd3,
    PP_TC   = 3'd4,
    PP_NONE = 3'd7
  } pipe_e;

  // true when different-unit mode forbids cand right after prev
  function automatic logic repeat_block(logic diff, pipe_e prev, pipe_e cand);
    return diff && (prev == cand);
  endfunction

  // pipe selection for one instruction; PP_NONE means it cannot issue
  function automatic pipe_e route_op(opclass_e cls, pipe_e prev, logic diff,
                                     logic int_on, logic dp_on,
                                     logic [NPIPE-1:0] avail);
    pipe_e sel;
    logic  general;
    sel     = PP_NONE;
    general = (cls == OC_SP) || (cls == OC_INT) || (cls == OC_ALUSFU);
    if (general) begin
      if (int_on && avail[PP_INT] && (cls != OC_SP) &&
          !repeat_block(diff, prev, PP_INT))
        sel = PP_INT;
      else if (avail[PP_SP] && (!int_on || (cls == OC_SP)) &&
               !repeat_block(diff, prev, PP_SP))
        sel = PP_SP;
      else if ((cls == OC_ALUSFU) && avail[PP_SFU] &&
               !repeat_block(diff, prev, PP_SFU))
        sel = PP_SFU;
    end else if ((cls == OC_DP) && dp_on) begin
      if (avail[PP_DP] && !repeat_block(diff, prev, PP_DP))
        sel = PP_DP;
    end else if ((cls == OC_DP) || (cls == OC_SFU)) begin
      if (avail[PP_SFU] && !repeat_block(diff, prev, PP_SFU))
        sel = PP_SFU;
    end else if (cls == OC_TC) begin
      if (avail[PP_TC] && !repeat_block(diff, prev, PP_SP))
        sel = PP_TC;
    end
    return sel;
  endfunction

endpackage

// File: rtl/wid_slot_cap.sv
module wid_slot_cap #(
  parameter int NUM_SCHED = 4,
  parameter int SID_W     = 2,
  parameter int CW        = 3
) (
  input  logic [NUM_SCHED-1:0] free_vec,
  input  logic                 sub_core,
  input  logic [SID_W-1:0]     sid,
  output logic [CW-1:0]        cap
);

  always_comb begin
    cap = '0;
    if (sub_core) begin
      cap = CW'(free_vec[sid]);
    end else begin
      for (int i = 0; i < NUM_SCHED; i++)
        cap = cap + CW'(free_vec[i]);
    end
  end

endmodule

// File: rtl/wid_stage.sv
module wid_stage
  import wid_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic                       go_in,
  input  logic                       vld,
  input  logic [2:0]                 cls,
  input  pipe_e                      prev_in,
  input  logic [NPIPE-1:0][CW-1:0]   used_in,
  input  logic [NPIPE-1:0][CW-1:0]   cap,
  input  logic                       diff,
  input  logic                       int_on,
  input  logic                       dp_on,
  output logic                       take,
  output pipe_e                      pipe_sel,
  output logic [NPIPE-1:0][CW-1:0]   used_out
);

  logic [NPIPE-1:0] avail;

  always_comb begin
    for (int p = 0; p < NPIPE; p++)
      avail[p] = used_in[p] < cap[p];
  end

  assign pipe_sel = route_op(opclass_e'(cls), prev_in, diff, int_on, dp_on, avail);
  assign take     = go_in && vld && (pipe_sel != PP_NONE);

  always_comb begin
    used_out = used_in;
    for (int p = 0; p < NPIPE; p++)
      if (take && (int'(pipe_sel) == p))
        used_out[p] = used_in[p] + CW'(1);
  end

endmodule

// File: rtl/warp_issue_dispatch.sv
module warp_issue_dispatch
  import wid_pkg::*;
#(
  parameter int MAX_ISSUE = 2,
  parameter int NUM_SCHED = 4,
  localparam int SID_W = (NUM_SCHED > 1) ? $clog2(NUM_SCHED) : 1,
  localparam int CNT_W = $clog2(MAX_ISSUE + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       diff_unit_en,
  input  logic                       sub_core_en,
  input  logic                       int_units_en,
  input  logic                       dp_units_en,
  input  logic [SID_W-1:0]           sched_id,
  input  logic                       warp_wait,
  input  logic [MAX_ISSUE-1:0]       ibuf_vld,
  input  logic [3*MAX_ISSUE-1:0]     ibuf_cls,
  input  logic [NUM_SCHED-1:0]       sp_free,
  input  logic [NUM_SCHED-1:0]       int_free,
  input  logic [NUM_SCHED-1:0]       dp_free,
  input  logic [NUM_SCHED-1:0]       sfu_free,
  input  logic [NUM_SCHED-1:0]       tc_free,
  output logic [NPIPE*MAX_ISSUE-1:0] o_strobe,
  output logic [CNT_W-1:0]           o_count
);

  localparam int BIG = (NUM_SCHED > MAX_ISSUE) ? NUM_SCHED : MAX_ISSUE;
  localparam int CW  = $clog2(BIG + 1);

  logic [NPIPE-1:0][NUM_SCHED-1:0] free_all;
  logic [NPIPE-1:0][CW-1:0]        cap;

  // named per-slot events, also observed by the checker
  logic [MAX_ISSUE-1:0]            slot_take;
  pipe_e                           slot_pipe [MAX_ISSUE];
  logic [MAX_ISSUE-1:0]            slot_go;
  pipe_e                           slot_prev [MAX_ISSUE];
  logic [NPIPE-1:0][CW-1:0]        used_c    [MAX_ISSUE+1];

  logic [NPIPE*MAX_ISSUE-1:0]      strobe_d;
  logic [CNT_W-1:0]                cnt_d;

  assign free_all = {tc_free, sfu_free, dp_free, int_free, sp_free};

  genvar p;
  generate
    for (p = 0; p < NPIPE; p++) begin : g_cap
      wid_slot_cap #(.NUM_SCHED(NUM_SCHED), .SID_W(SID_W), .CW(CW)) u_cap (
        .free_vec (free_all[p]),
        .sub_core (sub_core_en),
        .sid      (sched_id),
        .cap      (cap[p])
      );
    end
  endgenerate

  assign used_c[0] = '0;

  genvar k;
  generate
    for (k = 0; k < MAX_ISSUE; k++) begin : g_slot
      if (k == 0) begin : g_first
        assign slot_go[k]   = ~warp_wait;
        assign slot_prev[k] = PP_NONE;
      end else begin : g_next
        assign slot_go[k]   = slot_take[k-1];
        assign slot_prev[k] = slot_pipe[k-1];
      end

      wid_stage #(.CW(CW)) u_stg (
        .go_in    (slot_go[k]),
        .vld      (ibuf_vld[k]),
        .cls      (ibuf_cls[3*k +: 3]),
        .prev_in  (slot_prev[k]),
        .used_in  (used_c[k]),
        .cap      (cap),
        .diff     (diff_unit_en),
        .int_on   (int_units_en),
        .dp_on    (dp_units_en),
        .take     (slot_take[k]),
        .pipe_sel (slot_pipe[k]),
        .used_out (used_c[k+1])
      );

      assign strobe_d[NPIPE*k +: NPIPE] =
        slot_take[k] ? (NPIPE'(1) << slot_pipe[k]) : '0;
    end
  endgenerate

  // issued count taken from the capacity bookkeeping, not from the strobes
  always_comb begin
    cnt_d = '0;
    for (int q = 0; q < NPIPE; q++)
      cnt_d = cnt_d + CNT_W'(used_c[MAX_ISSUE][q]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_strobe <= '0;
      o_count  <= '0;
    end else begin
      o_strobe <= strobe_d;
      o_count  <= cnt_d;
    end
  end

endmodule

// File: rtl/wid_checker.sv
module wid_checker #(
  parameter int MAX_ISSUE = 2,
  parameter int NUM_SCHED = 4,
  localparam int SID_W = (NUM_SCHED > 1) ? $clog2(NUM_SCHED) : 1,
  localparam int CNT_W = $clog2(MAX_ISSUE + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   diff_unit_en,
  input logic                   sub_core_en,
  input logic [SID_W-1:0]       sched_id,
  input logic                   warp_wait,
  input logic [MAX_ISSUE-1:0]   ibuf_vld,
  input logic [3*MAX_ISSUE-1:0] ibuf_cls,
  input logic [NUM_SCHED-1:0]   tc_free,
  input logic [MAX_ISSUE-1:0]   slot_take,
  input logic [5*MAX_ISSUE-1:0] o_strobe,
  input logic [CNT_W-1:0]       o_count
);

  logic tc_any;
  always_comb begin
    tc_any = 1'b0;
    for (int k = 0; k < MAX_ISSUE; k++)
      tc_any = tc_any | o_strobe[5*k+4];
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (o_count == '0) && (o_strobe == '0));

  a_r2_wait_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    warp_wait |-> (slot_take == '0));

  a_r2_wait_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    warp_wait |=> (o_count == '0));

  a_r9_own_slot_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_core_en && !tc_free[sched_id]) |=> !tc_any);

  a_r10_mem_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (ibuf_vld[0] && (ibuf_cls[2:1] == 2'b11)) |=> (o_count == '0));

  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (o_count <= CNT_W'(MAX_ISSUE)) && ($countones(o_strobe) == int'(o_count)));

  genvar k;
  generate
    for (k = 0; k < MAX_ISSUE; k++) begin : g_slot
      a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(o_strobe[5*k +: 5]));
      if (k > 0) begin : g_pair
        a_r11_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
          (o_strobe[5*k +: 5] != '0) |-> (o_strobe[5*(k-1) +: 5] != '0));
        a_r8_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
          diff_unit_en |=> ((o_strobe[5*k +: 4] & o_strobe[5*(k-1) +: 4]) == '0));
        a_r7_tc_after_sp: assert property (@(posedge clk) disable iff (!rst_n)
          diff_unit_en |=> !(o_strobe[5*(k-1)] && o_strobe[5*k+4]));
      end
    end
  endgenerate

endmodule

bind warp_issue_dispatch wid_checker #(.MAX_ISSUE(MAX_ISSUE), .NUM_SCHED(NUM_SCHED)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .diff_unit_en (diff_unit_en),
  .sub_core_en  (sub_core_en),
  .sched_id     (sched_id),
  .warp_wait    (warp_wait),
  .ibuf_vld     (ibuf_vld),
  .ibuf_cls     (ibuf_cls),
  .tc_free      (tc_free),
  .slot_take    (slot_take),
  .o_strobe     (o_strobe),
  .o_count      (o_count)
);

// File: tb/sim_warp_issue_dispatch.sv
`timescale 1ns/1ps
module sim_warp_issue_dispatch;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       diff_unit_en = 1'b0, sub_core_en = 1'b0;
  logic       int_units_en = 1'b1, dp_units_en = 1'b1;
  logic [1:0] sched_id = '0;
  logic       warp_wait = 1'b0;
  logic [1:0] ibuf_vld = '0;
  logic [5:0] ibuf_cls = '0;
  logic [3:0] sp_free = '1, int_free = '1, dp_free = '1, sfu_free = '1, tc_free = '1;
  logic [9:0] o_strobe;
  logic [1:0] o_count;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  warp_issue_dispatch #(.MAX_ISSUE(2), .NUM_SCHED(4)) u0 (
    .clk(clk), .rst_n(rst_n), .diff_unit_en(diff_unit_en), .sub_core_en(sub_core_en),
    .int_units_en(int_units_en), .dp_units_en(dp_units_en), .sched_id(sched_id),
    .warp_wait(warp_wait), .ibuf_vld(ibuf_vld), .ibuf_cls(ibuf_cls),
    .sp_free(sp_free), .int_free(int_free), .dp_free(dp_free), .sfu_free(sfu_free),
    .tc_free(tc_free), .o_strobe(o_strobe), .o_count(o_count)
  );

  typedef struct packed {
    logic       diff, sub, ien, den, wt;
    logic [1:0] vld;
    logic [2:0] c0, c1;
    logic [1:0] sid;
    logic [3:0] fsp, fint, fdp, fsfu, ftc;
    logic [9:0] es;
    logic [1:0] ec;
    logic [3:0] rq;
  } vec_t;

  // strobe expectations: slot0 bits 4:0, slot1 bits 9:5; SP=1 INT=2 DP=4 SFU=8 TC=16
  localparam int NV = 30;
  localparam vec_t VT [NV] = '{
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b11,3'd1,3'd0,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h022,2'd2,4'd3},  // R3 INT then SP
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b11,3'd0,3'd0,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h021,2'd2,4'd4},  // R4 SP,SP
    '{1'b1,1'b0,1'b1,1'b1,1'b0,2'b11,3'd0,3'd0,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h001,2'd1,4'd8},  // R8 SP repeat
    '{1'b1,1'b0,1'b1,1'b1,1'b0,2'b11,3'd1,3'd1,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h002,2'd1,4'd8},  // R8 INT repeat
    '{1'b0,1'b0,1'b0,1'b1,1'b0,2'b11,3'd1,3'd4,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h021,2'd2,4'd4},  // R4 no int units
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b11,3'd0,3'd1,2'd0,4'h0,4'hF,4'hF,4'hF,4'hF,10'h000,2'd0,4'd2},  // R2 first fails
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b11,3'd2,3'd2,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h084,2'd2,4'd5},  // R5 DP,DP
    '{1'b1,1'b0,1'b1,1'b1,1'b0,2'b11,3'd2,3'd2,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h004,2'd1,4'd8},  // R8 DP repeat
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'b11,3'd2,3'd3,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h108,2'd2,4'd6},  // R6 DP on SFU
    '{1'b1,1'b0,1'b1,1'b0,1'b0,2'b11,3'd2,3'd3,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h008,2'd1,4'd8},  // R8 SFU repeat
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b11,3'd4,3'd5,2'd0,4'hF,4'h0,4'hF,4'hF,4'hF,10'h208,2'd2,4'd6},  // R6 ALU_SFU fallback
    '{1'b1,1'b0,1'b1,1'b1,1'b0,2'b11,3'd0,3'd5,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h001,2'd1,4'd7},  // R7 TC after SP
    '{1'b1,1'b0,1'b1,1'b1,1'b0,2'b11,3'd1,3'd5,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h202,2'd2,4'd7},  // R7 TC after INT
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b11,3'd5,3'd1,2'd0,4'hF,4'hF,4'hF,4'hF,4'h0,10'h000,2'd0,4'd7},  // R7 TC busy
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b11,3'd6,3'd1,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h000,2'd0,4'd10}, // R10 MEM first
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b11,3'd1,3'd6,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h002,2'd1,4'd10}, // R10 MEM second
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b11,3'd7,3'd1,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h000,2'd0,4'd10}, // R10 reserved
    '{1'b0,1'b0,1'b1,1'b1,1'b1,2'b11,3'd1,3'd1,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h000,2'd0,4'd2},  // R2 waiting
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b01,3'd1,3'd1,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h002,2'd1,4'd2},  // R2 one entry
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b10,3'd1,3'd1,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h000,2'd0,4'd2},  // R2 head empty
    '{1'b0,1'b1,1'b1,1'b1,1'b0,2'b11,3'd1,3'd1,2'd1,4'hF,4'h2,4'hF,4'hF,4'hF,10'h002,2'd1,4'd9},  // R9 own slot once
    '{1'b0,1'b1,1'b1,1'b1,1'b0,2'b11,3'd1,3'd0,2'd2,4'hF,4'hB,4'hF,4'hF,4'hF,10'h000,2'd0,4'd9},  // R9 own slot busy
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b11,3'd1,3'd1,2'd0,4'hF,4'h8,4'hF,4'hF,4'hF,10'h002,2'd1,4'd9},  // R9 shared one
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b11,3'd1,3'd1,2'd0,4'hF,4'h9,4'hF,4'hF,4'hF,10'h042,2'd2,4'd9},  // R9 shared two
    '{1'b0,1'b1,1'b1,1'b1,1'b0,2'b11,3'd0,3'd1,2'd0,4'h1,4'hF,4'hF,4'hF,4'hF,10'h041,2'd2,4'd9},  // R9 SP then INT
    '{1'b1,1'b0,1'b1,1'b1,1'b0,2'b11,3'd5,3'd5,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h210,2'd2,4'd7},  // R7 TC,TC allowed
    '{1'b1,1'b0,1'b1,1'b1,1'b0,2'b11,3'd3,3'd5,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h208,2'd2,4'd8},  // R8 SFU then TC
    '{1'b1,1'b0,1'b0,1'b1,1'b0,2'b11,3'd1,3'd0,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h001,2'd1,4'd8},  // R8 SP via no-int
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b11,3'd0,3'd4,2'd0,4'hF,4'hF,4'hF,4'hF,4'hF,10'h041,2'd2,4'd3},  // R3 ALU_SFU on INT
    '{1'b0,1'b1,1'b1,1'b1,1'b0,2'b11,3'd2,3'd2,2'd3,4'hF,4'hF,4'h8,4'hF,4'hF,10'h004,2'd1,4'd9}   // R9 DP own slot
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    diff_unit_en = v.diff; sub_core_en = v.sub; int_units_en = v.ien; dp_units_en = v.den;
    warp_wait = v.wt; ibuf_vld = v.vld; ibuf_cls = {v.c1, v.c0}; sched_id = v.sid;
    sp_free = v.fsp; int_free = v.fint; dp_free = v.fdp; sfu_free = v.fsfu; tc_free = v.ftc;
  endtask

  initial begin
    // R1: outputs held clear while reset is low, even with routable input
    drive(VT[0]);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 32'(o_strobe), 32'h0, "strobe in reset");
    chk("R1", 32'(o_count), 32'h0, "count in reset");
    @(negedge clk);
    ibuf_vld = '0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", 32'(o_strobe), 32'h0, "strobe idle after reset");
    chk("R1", 32'(o_count), 32'h0, "count idle after reset");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VT[i]);
      @(posedge clk); #1;
      chk($sformatf("R%0d vec%0d", VT[i].rq, i), 32'(o_strobe), 32'(VT[i].es), "strobe");
      chk($sformatf("R%0d vec%0d", VT[i].rq, i), 32'(o_count), 32'(VT[i].ec), "count");
      chk($sformatf("R11 vec%0d", i), 32'($countones(o_strobe)), 32'(o_count), "strobe/count agree");
    end

    // R2: outputs follow inputs by exactly one clock
    @(negedge clk);
    drive(VT[0]);
    #1;
    chk("R2", 32'(o_strobe), 32'(VT[NV-1].es), "no change before edge");
    @(posedge clk); #1;
    chk("R2", 32'(o_strobe), 32'h022, "updated after edge");

    // R1: asynchronous reset clears mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", 32'(o_count), 32'h0, "async clear");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule